// File: doc/BRIEF.md
# Banked Clock Divider and Router

This block sits behind a fast reference clock and turns it into four banks of three clock lines each. Two clocks are derived from the reference: one at half its rate and one at a quarter of its rate. Both are held at an even high/low split whatever the shape of the reference. A two-bit level input picks how many of the lower banks carry the quarter-rate clock. The remaining banks, and the top bank in every case, carry the half-rate clock.

Four further controls shape the outputs. An active-low enable gates every line, and a falling edge on a clear input restarts the quarter-rate divider. A test input swaps the divided clocks for a raw bypass clock. A settled flag drops for a fixed number of reference cycles after any event that disturbs the output pattern. The level, clear, test and enable inputs are synchronised into the reference domain before use. A new level takes effect only at a cycle where both divided clocks are low, so a bank never shows a truncated pulse when it changes rate.

Top module: `bank_clk_div`

## Requirements
- R1: The half-rate clock changes value on every reference rising edge, so it is high in 8 of any 16 consecutive cycles and shows 16 transitions across them.
- R2: The quarter-rate clock is high for two cycles and low for two cycles, so it shows 8 transitions and 8 high cycles in any 16-cycle window.
- R3: The three lines of one bank always carry the same value. Bank b drives bits `bank_o[3*b+2:3*b]`.
- R4: The level input `sel_i` is thermometer coded. Banks b < sel_i carry the quarter-rate clock and the others carry the half-rate clock. A level of 0 puts the half-rate clock on every bank, and a level of 3 puts the quarter-rate clock on banks 0, 1 and 2.
- R5: Bank 3 carries the half-rate clock for every level value.
- R6: While `oe_ni` is high, all twelve lines are low. This takes effect from the second reference edge after the input changes.
- R7: A falling edge on `clr_i` forces the quarter-rate clock low at the third reference edge after the fall. The half-rate clock keeps toggling through the clear.
- R8: From the second edge after `test_i` rises, every enabled line follows `byp_clk_i` combinationally.
- R9: `settled_o` is low during reset. It stays low for exactly SETTLE_CYC reference edges after reset is released, then goes high.
- R10: A change of the synchronised level, a high-to-low change of `oe_ni`, or a high-to-low change of `test_i` drops `settled_o` at the third edge after the input change. The flag rises again SETTLE_CYC edges later, and any new event restarts that count.
- R11: A new level is applied only at an edge where both divided clocks were low, so after a change every bank again shows the R1 or R2 pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 2 | Number of low banks that carry the quarter-rate clock |
| oe_ni | input | 1 | Output enable, active low; high forces all lines low |
| clr_i | input | 1 | Falling edge restarts the quarter-rate divider |
| test_i | input | 1 | High routes the bypass clock to every line |
| byp_clk_i | input | 1 | Raw clock used in test bypass |
| bank_o | output | 12 | Four banks of three clock lines, bank b at bits 3b+2..3b |
| settled_o | output | 1 | High when the output pattern has been stable for the settle interval |

## Verification
Every control passes through two synchroniser flops. Enable and test therefore act after the second edge, the clear reaches the quarter-rate divider at the third edge, and the settled flag drops at the third edge and rises SETTLE_CYC edges after that. The bench drives stimulus on falling edges, counts exactly that many falling edges, and samples there; the bypass path is combinational, so it is sampled 1 ns after the bypass clock is driven. Rate patterns are checked once the flag is settled, by counting transitions and high cycles per bank over a 16-cycle window. This makes those checks independent of the dividers' start phase.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int unsigned DEF_BANKS = 4;
  localparam int unsigned DEF_LINES = 3;

  // thermometer routing: bank takes the quarter-rate clock below the level
  function automatic logic bank_uses_quarter(int unsigned bank, int unsigned level);
    return bank < level;
  endfunction
endpackage

// File: rtl/bcd_sync.sv
module bcd_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/bcd_div.sv
module bcd_div (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic half_o,
  output logic quarter_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_o    <= 1'b0;
      quarter_o <= 1'b0;
    end else begin
      half_o <= ~half_o;
      if (clr_i)       quarter_o <= 1'b0;
      else if (half_o) quarter_o <= ~quarter_o;
    end
  end

  AST_HALF_TOGGLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (half_o != $past(half_o)));                              // R1
  AST_QUARTER_RISE_ON_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(quarter_o) |-> $past(half_o));                              // R2
  AST_CLR_QUARTER_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !quarter_o);                                            // R7
endmodule

// File: rtl/bcd_settle.sv
module bcd_settle #(
  parameter int unsigned SETTLE_CYC = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ev_i,
  output logic settled_o
);
  localparam int unsigned CNT_W = $clog2(SETTLE_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= CNT_W'(SETTLE_CYC);
    else if (ev_i)         cnt_q <= CNT_W'(SETTLE_CYC);
    else if (cnt_q != '0)  cnt_q <= cnt_q - CNT_W'(1);
  end

  assign settled_o = (cnt_q == '0);

  AST_EVENT_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i |=> !settled_o);                                             // R10
  AST_COUNT_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ev_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));  // R9
endmodule

// File: rtl/bank_clk_div.sv
module bank_clk_div
  import bcd_pkg::*;
#(
  parameter int unsigned NUM_BANKS      = DEF_BANKS,
  parameter int unsigned LINES_PER_BANK = DEF_LINES,
  parameter int unsigned SETTLE_CYC     = 64,
  parameter int unsigned SYNC_STAGES    = 2,
  localparam int unsigned SEL_W         = $clog2(NUM_BANKS),
  localparam int unsigned OUT_W         = NUM_BANKS * LINES_PER_BANK
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             oe_ni,
  input  logic             clr_i,
  input  logic             test_i,
  input  logic             byp_clk_i,
  output logic [OUT_W-1:0] bank_o,
  output logic             settled_o
);
  localparam int unsigned SYNC_W = SEL_W + 3;

  logic [SYNC_W-1:0] sync_d, sync_q;
  logic [SEL_W-1:0]  sel_s, sel_q, sel_act;
  logic              oe_s, oe_q, clr_s, clr_q, test_s, test_q;
  logic              clr_fall, cfg_ev;
  logic              half, quarter;
  logic [NUM_BANKS-1:0] bank_clk;

  assign sync_d = {sel_i, test_i, oe_ni, clr_i};

  bcd_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sync_d),
    .q_o   (sync_q)
  );

  assign {sel_s, test_s, oe_s, clr_s} = sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= '0;
      oe_q    <= 1'b0;
      clr_q   <= 1'b0;
      test_q  <= 1'b0;
      sel_act <= '0;
    end else begin
      sel_q  <= sel_s;
      oe_q   <= oe_s;
      clr_q  <= clr_s;
      test_q <= test_s;
      // switch routing only while both divided clocks sit low
      if (!half && !quarter) sel_act <= sel_s;
    end
  end

  assign clr_fall = clr_q & ~clr_s;
  assign cfg_ev   = (sel_s != sel_q) | (oe_q & ~oe_s) | (test_q & ~test_s);

  bcd_div u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr_fall),
    .half_o   (half),
    .quarter_o(quarter)
  );

  bcd_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ev_i     (cfg_ev),
    .settled_o(settled_o)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic line;
    assign bank_clk[b] = bank_uses_quarter(b, int'(sel_act)) ? quarter : half;
    assign line        = oe_s ? 1'b0 : (test_s ? byp_clk_i : bank_clk[b]);
    assign bank_o[b*LINES_PER_BANK +: LINES_PER_BANK] = {LINES_PER_BANK{line}};
  end

  AST_OE_FORCES_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_s |-> (bank_o == '0));                                         // R6
  AST_LAST_BANK_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_s && !test_s) |->
      (bank_o[(NUM_BANKS-1)*LINES_PER_BANK +: LINES_PER_BANK] == {LINES_PER_BANK{half}})); // R5
  AST_SEL_SWITCH_AT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_act != $past(sel_act)) |-> (!$past(half) && !$past(quarter))); // R11
endmodule

// File: tb/bank_clk_div_tb.sv
module bank_clk_div_tb;
  localparam int SETTLE = 16;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  sel_i = 2'd0;
  logic        oe_ni = 1'b0, clr_i = 1'b0, test_i = 1'b0, byp_clk_i = 1'b0;
  logic [11:0] bank_o;
  logic        settled_o;

  int checks = 0;
  int errors = 0;

  typedef struct {
    int    trans [4];
    int    highs [4];
    string tag;
  } exp_t;
  exp_t sb_q [$];

  bank_clk_div #(.SETTLE_CYC(SETTLE)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel_i), .oe_ni(oe_ni), .clr_i(clr_i),
    .test_i(test_i), .byp_clk_i(byp_clk_i), .bank_o(bank_o), .settled_o(settled_o)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic wait_settled();
    for (int i = 0; i < 200 && !settled_o; i++) tick(1);
    tick(6);
  endtask

  // driver: applies a level and pushes the per-bank pattern it should produce
  task automatic drive_level(input logic [1:0] lvl, input string tag);
    exp_t e;
    sel_i = lvl;
    wait_settled();
    for (int b = 0; b < 4; b++) begin
      e.trans[b] = (b < int'(lvl)) ? 8 : 16;
      e.highs[b] = 8;
    end
    e.tag = tag;
    sb_q.push_back(e);
    wait (sb_q.size() == 0);
  endtask

  task automatic settle_timing(input string tag);
    tick(2 + SETTLE);
    chk(settled_o == 1'b0, tag, settled_o, 0);
    tick(1);
    chk(settled_o == 1'b1, tag, settled_o, 1);
  endtask

  // monitor: measures a 16-cycle window and compares against the queue head
  initial begin
    exp_t e;
    int   tr [4];
    int   hi [4];
    int   bad [4];
    logic prev [4];
    forever begin
      wait (sb_q.size() != 0);
      e = sb_q[0];
      @(negedge clk);
      for (int b = 0; b < 4; b++) begin
        prev[b] = bank_o[3*b]; tr[b] = 0; hi[b] = 0; bad[b] = 0;
      end
      for (int c = 0; c < 16; c++) begin
        @(negedge clk);
        for (int b = 0; b < 4; b++) begin
          if (bank_o[3*b +: 3] != 3'b000 && bank_o[3*b +: 3] != 3'b111) bad[b]++;
          if (bank_o[3*b] != prev[b]) tr[b]++;
          if (bank_o[3*b]) hi[b]++;
          prev[b] = bank_o[3*b];
        end
      end
      for (int b = 0; b < 4; b++) begin
        chk(bad[b] == 0, {e.tag, " R3 lines equal"}, bad[b], 0);
        chk(tr[b] == e.trans[b], {e.tag, " transitions"}, tr[b], e.trans[b]);
        chk(hi[b] == e.highs[b], {e.tag, " high cycles"}, hi[b], e.highs[b]);
      end
      void'(sb_q.pop_front());
    end
  end

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int t3;
    logic p3;
    // reset state, R9
    tick(3);
    chk(bank_o == 12'h000, "R9 reset outputs", bank_o, 0);
    chk(settled_o == 1'b0, "R9 reset flag", settled_o, 0);
    rst_ni = 1'b1;
    tick(SETTLE - 1);
    chk(settled_o == 1'b0, "R9 flag before interval", settled_o, 0);
    tick(1);
    chk(settled_o == 1'b1, "R9 flag after interval", settled_o, 1);

    // R1 R2 R4 R5 level patterns
    drive_level(2'd0, "R4 R1 R5 level0");
    drive_level(2'd1, "R4 R2 level1");
    drive_level(2'd2, "R4 level2");
    drive_level(2'd3, "R4 R5 level3");
    drive_level(2'd1, "R11 level3to1");
    drive_level(2'd3, "R11 level1to3");

    // R10 settle after level change
    sel_i = 2'd2;
    settle_timing("R10 level change");
    sel_i = 2'd3;
    wait_settled();

    // R7 clear at four phases
    for (int ph = 0; ph < 4; ph++) begin
      clr_i = 1'b1;
      tick(4 + ph);
      clr_i = 1'b0;
      p3 = bank_o[9]; t3 = 0;
      for (int k = 0; k < 3; k++) begin
        tick(1);
        if (bank_o[9] != p3) t3++;
        p3 = bank_o[9];
      end
      chk(bank_o[2:0] == 3'b000, "R7 quarter cleared bank0", bank_o[2:0], 0);
      chk(bank_o[8:6] == 3'b000, "R7 quarter cleared bank2", bank_o[8:6], 0);
      chk(t3 == 3, "R7 half unaffected", t3, 3);
    end
    drive_level(2'd3, "R7 pattern after clear");

    // R6 enable
    oe_ni = 1'b1;
    tick(2);
    for (int k = 0; k < 8; k++) begin
      chk(bank_o == 12'h000, "R6 disabled low", bank_o, 0);
      tick(1);
    end
    oe_ni = 1'b0;
    settle_timing("R10 enable fall");
    drive_level(2'd2, "R6 pattern after enable");

    // R8 bypass
    test_i = 1'b1;
    tick(3);
    for (int k = 0; k < 4; k++) begin
      byp_clk_i = 1'b1; #1;
      chk(bank_o == 12'hfff, "R8 bypass high", bank_o, 12'hfff);
      byp_clk_i = 1'b0; #1;
      chk(bank_o == 12'h000, "R8 bypass low", bank_o, 0);
      tick(1);
    end
    oe_ni = 1'b1;
    tick(3);
    byp_clk_i = 1'b1; #1;
    chk(bank_o == 12'h000, "R6 bypass gated", bank_o, 0);
    byp_clk_i = 1'b0;
    oe_ni = 1'b0;
    wait_settled();
    tick(1);
    test_i = 1'b0;
    settle_timing("R10 test fall");
    drive_level(2'd1, "R8 pattern after bypass");

    finish_run();
  end
endmodule